// File: doc/BRIEF.md
# Bit Count, Parity and Bit-Gather Unit

A purely combinational 64-bit datapath block for the integer execute stage that performs a family of bit-manipulation operations on register values. Two operands and a 4-bit operation code enter. One 64-bit result leaves in the same cycle. No state is held and no status flags are produced. The operations are: ones counts at three granularities (byte lanes, 32-bit halves, whole doubleword), least-significant-bit parity per half and per doubleword, and leading-zero and trailing-zero counts over the low word or over the full doubleword. There are also a byte-equality mask and an 8-bit gather that picks operand-B bits named by big-endian indices held in the bytes of operand A.

The enclosing pipeline registers the operands and the result around this block. There is no state machine: the operation code selects one of several parallel sub-units through a single output multiplexer. Codes that have no operation assigned return zero.

Top module: `bop_unit`

## Requirements
- R1: With op_sel = 0, each byte lane of result holds the number of ones in the same byte lane of opnd_a.
- R2: With op_sel = 1, each 32-bit half of result holds the number of ones in the same half of opnd_a, zero-extended within that half.
- R3: With op_sel = 2, result holds the number of ones in all 64 bits of opnd_a.
- R4: With op_sel = 3, result bit 0 is the XOR of bit 0 of bytes 0..3 of opnd_a, result bit 32 is the XOR of bit 0 of bytes 4..7, and every other bit is zero.
- R5: With op_sel = 4, result bit 0 is the XOR of bit 0 of all eight bytes of opnd_a, and every other bit is zero.
- R6: With op_sel = 5, result is the number of leading zeros of opnd_a[31:0], which is 32 when that word is zero. With op_sel = 6, result is the leading-zero count of all 64 bits, which is 64 when opnd_a is zero.
- R7: With op_sel = 7, result is the number of trailing zeros of opnd_a[31:0], which is 32 when that word is zero. With op_sel = 8, result is the trailing-zero count of all 64 bits, which is 64 when opnd_a is zero.
- R8: With op_sel = 9, each result byte is 0xFF when the matching bytes of opnd_a and opnd_b are equal, and 0x00 otherwise.
- R9: With op_sel = 10, for each i from 0 to 7, byte i of opnd_a is an index n. Result bit i is opnd_b[63 − n] when n < 64 and 0 when n ≥ 64. Result bits 63..8 are zero.
- R10: Operation codes 11 to 15 give a result of zero, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 64 | Source operand; also the index source for the gather |
| opnd_b | input | 64 | Second operand, used by the byte compare and the gather |
| op_sel | input | 4 | Operation code, 0..10 (11..15 give zero) |
| result | output | 64 | Operation result |

## Verification
Random 64-bit operands are mixed with sparse patterns (single bits, all ones, zero). This shows whether each count stops at the correct first or last set bit, and whether the word forms ignore the upper half. Byte-compare operands are built as copies of each other with chosen bytes disturbed, so that equal and unequal lanes both appear. Gather indices are drawn both below and above 64, plus the edges 0, 63, 64 and 255. These separate the big-endian bit numbering from a little-endian one and confirm the zero for out-of-range indices. The unused codes are given non-zero operands, so a leak from any sub-unit would show.

// File: rtl/bop_pkg.sv
package bop_pkg;
    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_POP_BYTE  = 4'd0,
        OP_POP_WORD  = 4'd1,
        OP_POP_DWORD = 4'd2,
        OP_PAR_WORD  = 4'd3,
        OP_PAR_DWORD = 4'd4,
        OP_LZ_WORD   = 4'd5,
        OP_LZ_DWORD  = 4'd6,
        OP_TZ_WORD   = 4'd7,
        OP_TZ_DWORD  = 4'd8,
        OP_BYTE_EQ   = 4'd9,
        OP_GATHER    = 4'd10
    } bop_op_e;
endpackage

// File: rtl/bop_popcnt.sv
module bop_popcnt #(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] pop_byte,
    output logic [DATA_W-1:0] pop_word,
    output logic [DATA_W-1:0] pop_dword,
    output logic [DATA_W-1:0] par_word,
    output logic [DATA_W-1:0] par_dword
);
    localparam int unsigned NBYTE = DATA_W / 8;
    localparam int unsigned HALF  = DATA_W / 2;
    localparam int unsigned BPH   = NBYTE / 2;
    localparam int unsigned CW    = $clog2(DATA_W + 1);

    logic [3:0]    byte_cnt [NBYTE];
    logic [CW-1:0] half_cnt [2];
    logic [1:0]    half_par;

    // per-lane counters
    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        always_comb begin
            byte_cnt[g] = '0;
            for (int k = 0; k < 8; k++) begin
                byte_cnt[g] = byte_cnt[g] + 4'(src[8*g+k]);
            end
        end
        assign pop_byte[8*g +: 8] = {4'b0000, byte_cnt[g]};
    end

    // half-word counters and lsb parity
    for (genvar h = 0; h < 2; h++) begin : g_half
        always_comb begin
            half_cnt[h] = '0;
            half_par[h] = 1'b0;
            for (int j = 0; j < int'(BPH); j++) begin
                half_cnt[h] = half_cnt[h] + CW'(byte_cnt[h*BPH+j]);
                half_par[h] = half_par[h] ^ src[8*(h*BPH+j)];
            end
        end
        assign pop_word[h*HALF +: HALF] = HALF'(half_cnt[h]);
        assign par_word[h*HALF +: HALF] = HALF'(half_par[h]);
    end

    assign pop_dword = DATA_W'(half_cnt[0] + half_cnt[1]);
    assign par_dword = DATA_W'(half_par[0] ^ half_par[1]);
endmodule

// File: rtl/bop_zcount.sv
module bop_zcount #(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] lz_word,
    output logic [DATA_W-1:0] lz_dword,
    output logic [DATA_W-1:0] tz_word,
    output logic [DATA_W-1:0] tz_dword
);
    localparam int unsigned HALF = DATA_W / 2;
    localparam int unsigned CW   = $clog2(DATA_W + 1);

    // zeros above the first set bit inside the low w bits
    function automatic logic [CW-1:0] lead_z(input logic [DATA_W-1:0] v, input int w);
        logic [CW-1:0] n;
        logic          hit;
        n   = '0;
        hit = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (i < w && !hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 1'b1;
            end
        end
        return n;
    endfunction

    // zeros below the first set bit inside the low w bits
    function automatic logic [CW-1:0] trail_z(input logic [DATA_W-1:0] v, input int w);
        logic [CW-1:0] n;
        logic          hit;
        n   = '0;
        hit = 1'b0;
        for (int i = 0; i < int'(DATA_W); i++) begin
            if (i < w && !hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 1'b1;
            end
        end
        return n;
    endfunction

    always_comb begin
        lz_word  = DATA_W'(lead_z(src, int'(HALF)));
        lz_dword = DATA_W'(lead_z(src, int'(DATA_W)));
        tz_word  = DATA_W'(trail_z(src, int'(HALF)));
        tz_dword = DATA_W'(trail_z(src, int'(DATA_W)));
    end

    // R6 / R7: full-width counts saturate exactly when the operand is empty
    always_comb begin
        if (!$isunknown(src)) begin
            p_lz_full_r6: assert ((lz_dword == DATA_W'(DATA_W)) == (src == '0));
            p_tz_full_r7: assert ((tz_dword == DATA_W'(DATA_W)) == (src == '0));
            p_tz_word_r7: assert ((tz_word == DATA_W'(HALF)) == (src[HALF-1:0] == '0));
        end
    end
endmodule

// File: rtl/bop_bytewise.sv
module bop_bytewise #(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] eq_mask,
    output logic [DATA_W-1:0] gather
);
    localparam int unsigned NBYTE = DATA_W / 8;

    logic [NBYTE-1:0] pick;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        logic [7:0] idx;
        assign idx = src_a[8*g +: 8];
        assign eq_mask[8*g +: 8] = (src_a[8*g +: 8] == src_b[8*g +: 8]) ? 8'hFF : 8'h00;
        always_comb begin
            pick[g] = 1'b0;
            if (int'(idx) < int'(DATA_W)) begin
                pick[g] = src_b[int'(DATA_W) - 1 - int'(idx)];
            end
        end
    end

    assign gather = DATA_W'(pick);

    // R9: indices at or beyond the width never contribute a one
    always_comb begin
        if (!$isunknown(src_a) && !$isunknown(gather)) begin
            for (int g = 0; g < int'(NBYTE); g++) begin
                if (int'(src_a[8*g +: 8]) >= int'(DATA_W)) begin
                    p_gather_range_r9: assert (gather[g] == 1'b0);
                end
            end
        end
    end
endmodule

// File: rtl/bop_unit.sv
module bop_unit #(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [3:0]        op_sel,
    output logic [DATA_W-1:0] result
);
    import bop_pkg::*;

    localparam int unsigned HALF  = DATA_W / 2;
    localparam int unsigned NBYTE = DATA_W / 8;

    logic [DATA_W-1:0] pop_byte, pop_word, pop_dword, par_word, par_dword;
    logic [DATA_W-1:0] lz_word, lz_dword, tz_word, tz_dword;
    logic [DATA_W-1:0] eq_mask, gather;

    bop_popcnt #(.DATA_W(DATA_W)) u_popcnt (
        .src       (opnd_a),
        .pop_byte  (pop_byte),
        .pop_word  (pop_word),
        .pop_dword (pop_dword),
        .par_word  (par_word),
        .par_dword (par_dword)
    );

    bop_zcount #(.DATA_W(DATA_W)) u_zcount (
        .src      (opnd_a),
        .lz_word  (lz_word),
        .lz_dword (lz_dword),
        .tz_word  (tz_word),
        .tz_dword (tz_dword)
    );

    bop_bytewise #(.DATA_W(DATA_W)) u_bytewise (
        .src_a   (opnd_a),
        .src_b   (opnd_b),
        .eq_mask (eq_mask),
        .gather  (gather)
    );

    always_comb begin
        unique case (op_sel)
            OP_POP_BYTE:  result = pop_byte;
            OP_POP_WORD:  result = pop_word;
            OP_POP_DWORD: result = pop_dword;
            OP_PAR_WORD:  result = par_word;
            OP_PAR_DWORD: result = par_dword;
            OP_LZ_WORD:   result = lz_word;
            OP_LZ_DWORD:  result = lz_dword;
            OP_TZ_WORD:   result = tz_word;
            OP_TZ_DWORD:  result = tz_dword;
            OP_BYTE_EQ:   result = eq_mask;
            OP_GATHER:    result = gather;
            default:      result = '0;
        endcase
    end

    // output-side checks relating result to operands and op code
    always_comb begin
        if (!$isunknown(op_sel) && !$isunknown(result) && !$isunknown(opnd_a)) begin
            if (op_sel == OP_POP_DWORD)
                p_pop_bound_r3: assert (result <= DATA_W'(DATA_W));
            if (op_sel == OP_PAR_WORD)
                p_par_word_sparse_r4: assert ((result & ~(DATA_W'(1) | (DATA_W'(1) << HALF))) == '0);
            if (op_sel == OP_PAR_DWORD)
                p_par_dword_sparse_r5: assert (result[DATA_W-1:1] == '0);
            if (op_sel == OP_LZ_WORD)
                p_lz_word_zero_r6: assert ((result == DATA_W'(HALF)) == (opnd_a[HALF-1:0] == '0));
            if (op_sel == OP_GATHER)
                p_gather_width_r9: assert (result[DATA_W-1:NBYTE] == '0);
            if (op_sel > 4'(OP_GATHER))
                p_unused_zero_r10: assert (result == '0);
        end
        if (!$isunknown(op_sel) && !$isunknown(result) && op_sel == OP_BYTE_EQ) begin
            for (int g = 0; g < int'(NBYTE); g++) begin
                p_eq_lane_r8: assert (result[8*g +: 8] == 8'hFF || result[8*g +: 8] == 8'h00);
            end
        end
    end
endmodule

// File: tb/bop_unit_tb.sv
module bop_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [3:0]  op_sel = '0;
    logic [63:0] result;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    int          cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    bop_unit dut_i (.opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result));

    function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        int n;
        case (op)
            4'd0: for (int i = 0; i < 8; i++) r[8*i +: 8] = 8'($countones(a[8*i +: 8]));
            4'd1: begin
                r[31:0]  = 32'($countones(a[31:0]));
                r[63:32] = 32'($countones(a[63:32]));
            end
            4'd2: r = 64'($countones(a));
            4'd3: begin
                r[0]  = a[0] ^ a[8] ^ a[16] ^ a[24];
                r[32] = a[32] ^ a[40] ^ a[48] ^ a[56];
            end
            4'd4: r[0] = a[0] ^ a[8] ^ a[16] ^ a[24] ^ a[32] ^ a[40] ^ a[48] ^ a[56];
            4'd5: begin n = 0; while (n < 32 && !a[31-n]) n++; r = 64'(n); end
            4'd6: begin n = 0; while (n < 64 && !a[63-n]) n++; r = 64'(n); end
            4'd7: begin n = 0; while (n < 32 && !a[n]) n++; r = 64'(n); end
            4'd8: begin n = 0; while (n < 64 && !a[n]) n++; r = 64'(n); end
            4'd9: for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[8*i +: 8] == b[8*i +: 8]) ? 8'hFF : 8'h00;
            4'd10: for (int i = 0; i < 8; i++) begin
                n = int'(a[8*i +: 8]);
                if (n < 64) r[i] = b[63-n];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
            4'd3: return "R4";  4'd4: return "R5";
            4'd5, 4'd6: return "R6";
            4'd7, 4'd8: return "R7";
            4'd9: return "R8";  4'd10: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] exp;
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        exp = model(op, a, b);
        @(negedge clk);
        n_chk++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req_of(op), op, a, b, result, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        logic [63:0] a, b;
        logic [3:0]  op;
        seed = $urandom(32'h5EED_B17);
        // reset state: zero operands, op 0 -> zero result
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (result !== 64'h0) begin
            n_fail++;
            $display("FAIL R1 reset actual=%h expected=%h", result, 64'h0);
        end
        rst_n = 1'b1;

        // directed corners
        apply(4'd0, 64'hFF00_0F01_8000_00FF, '0);            // R1
        apply(4'd1, 64'hFFFF_FFFF_0000_0001, '0);            // R2
        apply(4'd2, 64'hFFFF_FFFF_FFFF_FFFF, '0);            // R3 max
        apply(4'd3, 64'h0100_0001_0001_0101, '0);            // R4
        apply(4'd4, 64'h0101_0101_0101_0100, '0);            // R5
        apply(4'd5, 64'hFFFF_FFFF_0000_0000, '0);            // R6 low word zero -> 32
        apply(4'd6, 64'h0, '0);                              // R6 zero -> 64
        apply(4'd6, 64'h8000_0000_0000_0000, '0);            // R6 top bit -> 0
        apply(4'd7, 64'h0000_0001_0000_0000, '0);            // R7 low word zero -> 32
        apply(4'd8, 64'h0, '0);                              // R7 zero -> 64
        apply(4'd8, 64'h8000_0000_0000_0000, '0);            // R7 -> 63
        apply(4'd9, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788); // R8
        apply(4'd10, 64'h40FF_3F00_0001_3E3F, 64'h8000_0000_0000_0001); // R9 edges 0,63,64,255
        apply(4'd10, 64'h0001_0203_0405_0607, 64'hA500_0000_0000_0000); // R9 big-endian order
        for (int c = 11; c < 16; c++) apply(4'(c), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R10

        // constrained random
        for (int t = 0; t < 600; t++) begin
            op = 4'($urandom % 16);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            case ($urandom % 4)
                0: a = 64'h1 << ($urandom % 64);        // single bit for counts
                1: if (op == 4'd9) b = a ^ (64'hFF << (8 * ($urandom % 8)) & {$urandom, $urandom});
                2: if (op == 4'd10) a = a & 64'h7F7F_7F7F_7F7F_7F7F; // mix in-range indices
                default: ;
            endcase
            apply(op, a, b);
        end
        finish_run();
    end
endmodule